// File: doc/BRIEF.md
# Frame-Tagged Stack Region Guard

This block watches the local arrays that a running program places on its stack. It holds a small bank of region slots. Each slot records a start address, a length given as a number of elements, and a frame tag. The tag names the function invocation that owns the array. Software claims a slot when a function declares a local array. Every array that belongs to one call carries the same tag. When the call returns, a single drop command carrying that tag frees all of that call's slots in the same cycle. Tags are handed out in increasing order, one for each function entry.

Any address can be presented for checking. The bank reports, one cycle later, whether the address falls inside a live region, and which tag owns it. Hits travel along a cascade from slot 0 upward, so the lowest-numbered matching slot supplies the reported tag. Claims travel along a second chain that gives each request to the lowest-numbered free slot. When a claim reaches the end of that chain unserved, the active-low fallback line is asserted.

Each slot runs a two-state machine:
- `SLOT_FREE` goes to `SLOT_HELD` when a claim reaches the slot.
- `SLOT_HELD` goes to `SLOT_FREE` when a drop command carries the slot's tag.

The bank controller has two states:
- `BANK_OK` goes to `BANK_EXHAUSTED` when a claim finds no free slot.
- `BANK_EXHAUSTED` goes back to `BANK_OK` when a drop command frees at least one slot.

Top module: `stk_frame_guard`

## Requirements
- R1: After reset every slot is free, `fallback_n` is 1, and `chk_rsp_valid`, `chk_hit` and `chk_frame` are 0.
- R2: A command with `cmd_op` = 2'b01 (claim) loads `cmd_base`, `cmd_count` and `cmd_frame` into the lowest-numbered free slot. The region can be seen by checks issued from the next cycle onward.
- R3: A check (`chk_valid` = 1) gets its answer in the next cycle, on `chk_rsp_valid`. The check hits when some held slot satisfies the unsigned test (`chk_addr` − base) < count × 4. `chk_frame` then shows the tag of the lowest-numbered hitting slot; on a miss it shows 0.
- R4: A command with `cmd_op` = 2'b10 (drop) frees, in one cycle, every held slot whose tag equals `cmd_frame`.
- R5: A drop whose tag matches no held slot changes no slot and does not change `fallback_n`.
- R6: A claim that finds every slot held changes no slot. It drives `fallback_n` low from the next cycle, and `fallback_n` stays low until a drop frees at least one slot.
- R7: A check made in the same cycle as a drop does not hit any slot that the drop frees. Slots that the drop does not free still hit.
- R8: The last element of a region (base + count×4 − 1) hits. The byte after the region and the byte before the base miss. A region with count 0 never hits. A region that runs past the top of the address space wraps around to address 0.
- R9: `cmd_op` = 2'b00 (idle) and 2'b11 (reserved) have no effect on any slot.
- R10: In a cycle that follows no check, `chk_rsp_valid` and `chk_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 2 | 00 idle, 01 claim, 10 drop by tag, 11 reserved |
| cmd_base | input | AW | Start address of the region being claimed |
| cmd_count | input | CNT_W | Element count of the region being claimed |
| cmd_frame | input | FW | Frame tag for a claim or a drop |
| chk_valid | input | 1 | Check request |
| chk_addr | input | AW | Address to check |
| chk_rsp_valid | output | 1 | Check answer valid, one cycle after `chk_valid` |
| chk_hit | output | 1 | Checked address lies in a live region |
| chk_frame | output | FW | Tag of the lowest-numbered hitting slot, 0 on a miss |
| fallback_n | output | 1 | Low while a claim has found the bank full |

## Verification
The bench probes the region edges one byte on each side, a region of zero length, and a region that wraps past the top of the address space. An off-by-one compare, or a signed subtraction, would flip one of these answers. Two overlapping regions owned by different tags show whether the cascade keeps the lowest slot's tag rather than the last one. A drop is made against two slots that share a tag, and a drop is made with an unknown tag, to catch a design that frees only one slot or frees the wrong ones. A claim is sent to a full bank, and the bench then follows `fallback_n` through a drop that frees nothing and a drop that frees slots; a design that let the claim overwrite a slot, or that cleared the flag too early, fails here. A check issued in the same cycle as a drop shows whether a slot that is being freed still answers.

// File: rtl/stk_guard_pkg.sv
package stk_guard_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_CLAIM = 2'b01,
        OP_DROP  = 2'b10,
        OP_RSVD  = 2'b11
    } stk_op_e;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    typedef enum logic {
        BANK_OK        = 1'b0,
        BANK_EXHAUSTED = 1'b1
    } bank_state_e;

endpackage

// File: rtl/stk_guard_slot.sv
module stk_guard_slot
    import stk_guard_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CNT_W      = 12,
    parameter int FW         = 8,
    parameter int ELEM_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim_in,
    output logic             claim_out,
    input  logic             drop_req,
    input  logic [FW-1:0]    drop_frame,
    input  logic [AW-1:0]    cmd_base,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic [FW-1:0]    cmd_frame,
    input  logic [AW-1:0]    chk_addr,
    input  logic             hit_in,
    input  logic [FW-1:0]    hit_frame_in,
    output logic             hit_out,
    output logic [FW-1:0]    hit_frame_out,
    output logic             held,
    output logic [FW-1:0]    frame,
    output logic             dropping
);

    slot_state_e      state_q, state_d;
    logic [AW-1:0]    base_q;
    logic [CNT_W-1:0] count_q;
    logic [FW-1:0]    frame_q;
    logic [AW-1:0]    span;
    logic [AW-1:0]    offset;
    logic             take;
    logic             region_hit;

    // The claim stops at the first free slot; anything left goes on down the chain.
    assign take      = claim_in && (state_q == SLOT_FREE);
    assign claim_out = claim_in && (state_q != SLOT_FREE);
    assign dropping  = drop_req && (state_q == SLOT_HELD) && (frame_q == drop_frame);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (take)     state_d = SLOT_HELD;
            SLOT_HELD: if (dropping) state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            count_q <= '0;
            frame_q <= '0;
        end else if (take) begin
            base_q  <= cmd_base;
            count_q <= cmd_count;
            frame_q <= cmd_frame;
        end
    end

    // Unsigned distance from the base covers the lower bound, the upper bound
    // and wrap past the top of the address space with one compare.
    assign span       = AW'(count_q) << ELEM_SHIFT;
    assign offset     = chk_addr - base_q;
    assign region_hit = (state_q == SLOT_HELD) && !dropping && (offset < span);

    always_comb begin
        hit_out       = hit_in | region_hit;
        hit_frame_out = hit_in ? hit_frame_in : (region_hit ? frame_q : '0);
        held          = (state_q == SLOT_HELD);
        frame         = frame_q;
    end

endmodule

// File: rtl/stk_guard_ctrl.sv
module stk_guard_ctrl
    import stk_guard_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim_req,
    input  logic          claim_miss,
    input  logic          any_drop,
    input  logic          chk_valid,
    input  logic          hit_any,
    input  logic [FW-1:0] hit_frame,
    output logic          rsp_valid,
    output logic          rsp_hit,
    output logic [FW-1:0] rsp_frame,
    output logic          fallback_n
);

    bank_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_OK:        if (claim_req && claim_miss) state_d = BANK_EXHAUSTED;
            BANK_EXHAUSTED: if (any_drop)                state_d = BANK_OK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BANK_OK;
        else        state_q <= state_d;
    end

    always_comb begin
        fallback_n = (state_q != BANK_EXHAUSTED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_frame <= '0;
        end else begin
            rsp_valid <= chk_valid;
            rsp_hit   <= chk_valid && hit_any;
            rsp_frame <= (chk_valid && hit_any) ? hit_frame : '0;
        end
    end

endmodule

// File: rtl/stk_frame_guard.sv
module stk_frame_guard
    import stk_guard_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int AW         = 32,
    parameter int CNT_W      = 12,
    parameter int FW         = 8,
    parameter int ELEM_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd_op,
    input  logic [AW-1:0]    cmd_base,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic [FW-1:0]    cmd_frame,
    input  logic             chk_valid,
    input  logic [AW-1:0]    chk_addr,
    output logic             chk_rsp_valid,
    output logic             chk_hit,
    output logic [FW-1:0]    chk_frame,
    output logic             fallback_n
);

    stk_op_e                          op_e;
    logic                             claim_req;
    logic                             drop_req;
    logic [NUM_SLOTS:0]               claim_chain;
    logic [NUM_SLOTS:0]               hit_chain;
    logic [NUM_SLOTS:0][FW-1:0]       frame_chain;
    logic [NUM_SLOTS-1:0]             slot_held;
    logic [NUM_SLOTS-1:0]             slot_drop;
    logic [NUM_SLOTS-1:0][FW-1:0]     slot_frame;

    assign op_e      = stk_op_e'(cmd_op);
    assign claim_req = (op_e == OP_CLAIM);
    assign drop_req  = (op_e == OP_DROP);

    assign claim_chain[0] = claim_req;
    assign hit_chain[0]   = 1'b0;
    assign frame_chain[0] = '0;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        stk_guard_slot #(
            .AW(AW), .CNT_W(CNT_W), .FW(FW), .ELEM_SHIFT(ELEM_SHIFT)
        ) u_slot (
            .clk           (clk),
            .rst_n         (rst_n),
            .claim_in      (claim_chain[i]),
            .claim_out     (claim_chain[i+1]),
            .drop_req      (drop_req),
            .drop_frame    (cmd_frame),
            .cmd_base      (cmd_base),
            .cmd_count     (cmd_count),
            .cmd_frame     (cmd_frame),
            .chk_addr      (chk_addr),
            .hit_in        (hit_chain[i]),
            .hit_frame_in  (frame_chain[i]),
            .hit_out       (hit_chain[i+1]),
            .hit_frame_out (frame_chain[i+1]),
            .held          (slot_held[i]),
            .frame         (slot_frame[i]),
            .dropping      (slot_drop[i])
        );
    end

    stk_guard_ctrl #(.FW(FW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .claim_req  (claim_req),
        .claim_miss (claim_chain[NUM_SLOTS]),
        .any_drop   (|slot_drop),
        .chk_valid  (chk_valid),
        .hit_any    (hit_chain[NUM_SLOTS]),
        .hit_frame  (frame_chain[NUM_SLOTS]),
        .rsp_valid  (chk_rsp_valid),
        .rsp_hit    (chk_hit),
        .rsp_frame  (chk_frame),
        .fallback_n (fallback_n)
    );

endmodule

// File: rtl/stk_frame_guard_sva.sv
module stk_frame_guard_sva #(
    parameter int NUM_SLOTS = 4,
    parameter int FW        = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [1:0]                   cmd_op,
    input logic [FW-1:0]                cmd_frame,
    input logic                         chk_valid,
    input logic                         chk_rsp_valid,
    input logic                         chk_hit,
    input logic                         fallback_n,
    input logic [NUM_SLOTS-1:0]         held_vec,
    input logic [NUM_SLOTS-1:0][FW-1:0] frame_vec
);

    assert_rsp_follows_check_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_rsp_valid);

    assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> (!chk_rsp_valid && !chk_hit));

    assert_claim_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b01 && !(&held_vec)) |=>
            ($countones(held_vec) == $countones($past(held_vec)) + 1));

    assert_full_claim_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b01 && (&held_vec)) |=> (!fallback_n && held_vec == $past(held_vec)));

    assert_exhausted_means_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fallback_n |-> (&held_vec));

    assert_idle_ops_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'b00 || cmd_op == 2'b11) |=> (held_vec == $past(held_vec)));

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_chk
        assert_drop_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_op == 2'b10 && held_vec[i] && frame_vec[i] == cmd_frame) |=> !held_vec[i]);

        assert_drop_spares_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_op == 2'b10 && held_vec[i] && frame_vec[i] != cmd_frame) |=>
                (held_vec[i] && $stable(frame_vec[i])));
    end

endmodule

bind stk_frame_guard stk_frame_guard_sva #(
    .NUM_SLOTS(NUM_SLOTS),
    .FW(FW)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_op        (cmd_op),
    .cmd_frame     (cmd_frame),
    .chk_valid     (chk_valid),
    .chk_rsp_valid (chk_rsp_valid),
    .chk_hit       (chk_hit),
    .fallback_n    (fallback_n),
    .held_vec      (slot_held),
    .frame_vec     (slot_frame)
);

// File: tb/stk_frame_guard_bench.sv
module stk_frame_guard_bench;

    localparam int AW    = 32;
    localparam int CNT_W = 12;
    localparam int FW    = 8;
    localparam int WATCHDOG_CYCLES = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cmd_op = 2'b00;
    logic [AW-1:0]    cmd_base = '0;
    logic [CNT_W-1:0] cmd_count = '0;
    logic [FW-1:0]    cmd_frame = '0;
    logic             chk_valid = 1'b0;
    logic [AW-1:0]    chk_addr = '0;
    logic             chk_rsp_valid;
    logic             chk_hit;
    logic [FW-1:0]    chk_frame;
    logic             fallback_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    stk_frame_guard u_stk_frame_guard (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_base(cmd_base),
        .cmd_count(cmd_count), .cmd_frame(cmd_frame), .chk_valid(chk_valid),
        .chk_addr(chk_addr), .chk_rsp_valid(chk_rsp_valid), .chk_hit(chk_hit),
        .chk_frame(chk_frame), .fallback_n(fallback_n)
    );

    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic claim(input logic [AW-1:0] base, input logic [CNT_W-1:0] cnt,
                         input logic [FW-1:0] fr);
        cmd_op = 2'b01; cmd_base = base; cmd_count = cnt; cmd_frame = fr;
        step();
        cmd_op = 2'b00;
    endtask

    task automatic drop(input logic [FW-1:0] fr);
        cmd_op = 2'b10; cmd_frame = fr;
        step();
        cmd_op = 2'b00;
    endtask

    task automatic probe(input string req, input logic [AW-1:0] addr,
                         input logic exp_hit, input logic [FW-1:0] exp_frame);
        chk_valid = 1'b1; chk_addr = addr;
        step();
        chk_valid = 1'b0;
        expect_eq(req, "rsp_valid", 32'(chk_rsp_valid), 32'd1);
        expect_eq(req, "hit", 32'(chk_hit), 32'(exp_hit));
        expect_eq(req, "frame", 32'(chk_frame), 32'(exp_frame));
    endtask

    task automatic t_reset();
        expect_eq("R1", "fallback_n", 32'(fallback_n), 32'd1);
        expect_eq("R1", "rsp_valid", 32'(chk_rsp_valid), 32'd0);
        expect_eq("R1", "hit", 32'(chk_hit), 32'd0);
        probe("R1", 32'h0000_0000, 1'b0, 8'd0);
    endtask

    task automatic t_bounds();
        claim(32'h1000, 12'd10, 8'd1);             // span 0x28
        probe("R2", 32'h1000, 1'b1, 8'd1);
        probe("R8", 32'h1027, 1'b1, 8'd1);
        probe("R8", 32'h1028, 1'b0, 8'd0);
        probe("R8", 32'h0FFF, 1'b0, 8'd0);
        claim(32'h2000, 12'd0, 8'd1);              // zero length, same tag
        probe("R8", 32'h2000, 1'b0, 8'd0);
    endtask

    task automatic t_overlap();
        claim(32'h1010, 12'd4, 8'd2);              // slot 2, inside slot 0 region
        probe("R3", 32'h1014, 1'b1, 8'd1);         // lowest slot wins
        probe("R3", 32'h101F, 1'b1, 8'd1);
    endtask

    task automatic t_drop();
        drop(8'd1);                                // frees slots 0 and 1
        probe("R4", 32'h1004, 1'b0, 8'd0);
        probe("R4", 32'h1014, 1'b1, 8'd2);
        drop(8'd9);
        probe("R5", 32'h1014, 1'b1, 8'd2);
        expect_eq("R5", "fallback_n", 32'(fallback_n), 32'd1);
    endtask

    task automatic t_inert_ops();
        cmd_op = 2'b11; cmd_frame = 8'd2; cmd_base = 32'h5000; cmd_count = 12'd4;
        step();
        cmd_op = 2'b00;
        step();
        probe("R9", 32'h1014, 1'b1, 8'd2);
        probe("R9", 32'h5000, 1'b0, 8'd0);
    endtask

    task automatic t_exhaust();
        claim(32'h3000, 12'd1, 8'd3);
        claim(32'h3100, 12'd1, 8'd3);
        claim(32'h3200, 12'd1, 8'd3);
        expect_eq("R6", "fallback_n before full claim", 32'(fallback_n), 32'd1);
        claim(32'h4000, 12'd4, 8'd4);
        expect_eq("R6", "fallback_n after full claim", 32'(fallback_n), 32'd0);
        probe("R6", 32'h4000, 1'b0, 8'd0);
        probe("R6", 32'h3200, 1'b1, 8'd3);
        drop(8'd44);
        expect_eq("R6", "fallback_n after empty drop", 32'(fallback_n), 32'd0);
        drop(8'd3);
        expect_eq("R6", "fallback_n after freeing drop", 32'(fallback_n), 32'd1);
        claim(32'h4000, 12'd4, 8'd4);
        probe("R2", 32'h400C, 1'b1, 8'd4);
    endtask

    task automatic t_wrap();
        claim(32'hFFFF_FFF0, 12'd8, 8'd5);         // span 0x20 crosses zero
        probe("R8", 32'h0000_000C, 1'b1, 8'd5);
        probe("R8", 32'h0000_0010, 1'b0, 8'd0);
        probe("R8", 32'hFFFF_FFEF, 1'b0, 8'd0);
    endtask

    task automatic t_same_cycle();
        cmd_op = 2'b10; cmd_frame = 8'd2; chk_valid = 1'b1; chk_addr = 32'h1010;
        step();
        cmd_op = 2'b00; chk_valid = 1'b0;
        expect_eq("R7", "hit while dropping", 32'(chk_hit), 32'd0);
        cmd_op = 2'b10; cmd_frame = 8'd7; chk_valid = 1'b1; chk_addr = 32'h4000;
        step();
        cmd_op = 2'b00; chk_valid = 1'b0;
        expect_eq("R7", "hit beside unrelated drop", 32'(chk_hit), 32'd1);
        expect_eq("R7", "frame beside unrelated drop", 32'(chk_frame), 32'd4);
    endtask

    task automatic t_idle_rsp();
        step();
        expect_eq("R10", "rsp_valid idle", 32'(chk_rsp_valid), 32'd0);
        expect_eq("R10", "hit idle", 32'(chk_hit), 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG_CYCLES) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG_CYCLES);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bounds();
        t_overlap();
        t_drop();
        t_inert_ops();
        t_exhaust();
        t_wrap();
        t_same_cycle();
        t_idle_rsp();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule